// File: doc/BRIEF.md
# Packet Header Field Match Cell

This block checks one field of each packet against a programmed rule. Packet bytes arrive one per beat, with a valid strobe and markers for the first and last byte. The cell locates the field at a programmed byte offset and reads between one and four bytes of it. It masks the field and compares the result with a programmed value. One cycle after the last byte, it gives a verdict for the packet.

The verdict carries three flags. The first is a match flag. The second is a bounds flag, raised when the field would extend past the end of the packet. The third is an alignment flag, raised when the field does not start on a 4-byte boundary.

The rule can be rewritten at any time. Each packet uses the rule that was in force when its first byte arrived, so a rewrite never changes the verdict of a packet already in flight. Cells of this kind are placed side by side in a demultiplexing front end, where each one answers a single branch question about the header.

Top module: `hdr_field_match`

## Requirements
- R1: After reset, all verdict outputs are low and the rule in force is offset 0, length WORD_BYTES, mask 0, value 0. With this rule, a packet of at least WORD_BYTES bytes matches.
- R2: The field is assembled in network byte order. The byte at the programmed offset lands in bits 31:24, the next byte in bits 23:16, and so on. Byte lanes beyond the programmed length read as zero.
- R3: The match flag is high only when (field AND mask) equals value. verdict_valid_o pulses for exactly one cycle, in the cycle after the beat that carries last. Outside that pulse, match_o, out_of_bounds_o and misaligned_o are low.
- R4: out_of_bounds_o is set when offset + length is greater than the packet's byte count. When it is set, match_o is low, whatever the mask and value would give.
- R5: misaligned_o is set when offset modulo WORD_BYTES is non-zero. This is independent of the bounds result.
- R6: Cycles with s_valid_i low do not advance the byte position and do not alter the captured field.
- R7: A rule write reaches the datapath at the next beat that carries first. A write made during a packet leaves that packet's verdict unchanged and applies from the following packet. A write in the same cycle as a first beat also waits for the packet after that one.
- R8: A rule write whose length is 0 or greater than WORD_BYTES is discarded as a whole, and the previous rule stays in force.
- R9: A packet of one beat, with first and last high together, receives a complete verdict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Rule write strobe |
| cfg_offset_i | input | OFF_W | Field byte offset from packet start |
| cfg_len_i | input | LEN_W | Field length in bytes, 1..WORD_BYTES |
| cfg_mask_i | input | FIELD_W | Mask applied to the assembled field |
| cfg_value_i | input | FIELD_W | Expected masked field value |
| s_valid_i | input | 1 | Byte beat valid |
| s_first_i | input | 1 | Beat carries the packet's first byte |
| s_last_i | input | 1 | Beat carries the packet's last byte |
| s_data_i | input | 8 | Packet byte |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| match_o | output | 1 | Masked field equals value |
| out_of_bounds_o | output | 1 | Field runs past packet end |
| misaligned_o | output | 1 | Field offset not word aligned |

## Verification
The bench builds the cell with its defaults: WORD_BYTES = 4 and OFF_W = 8. These values bring every field length from 1 to 4 bytes within reach, and every alignment residue. They also allow packets short enough that a field exactly touching the last byte, and one overrunning it by a byte, can both be reached in a few beats. Packets of up to 16 bytes place fields in the middle, at the start and at the very end. Idle gaps, one-beat packets and mid-packet rule writes exercise the position counter and the rule-latching point.

// File: rtl/hfm_pkg.sv
package hfm_pkg;
  localparam int unsigned HFM_BYTE_W     = 8;
  localparam int unsigned HFM_WORD_BYTES = 4;
  localparam int unsigned HFM_OFF_W      = 8;
endpackage

// File: rtl/hfm_cfg.sv
module hfm_cfg #(
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned FIELD_W    = 32,
  parameter int unsigned WORD_BYTES = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] value_i,
  input  logic               load_i,
  output logic [OFF_W-1:0]   off_o,
  output logic [LEN_W-1:0]   len_o,
  output logic [FIELD_W-1:0] mask_o,
  output logic [FIELD_W-1:0] value_o
);
  logic [OFF_W-1:0]   sh_off, ac_off;
  logic [LEN_W-1:0]   sh_len, ac_len;
  logic [FIELD_W-1:0] sh_mask, ac_mask, sh_val, ac_val;
  logic               wr_ok;

  assign wr_ok = we_i && (len_i != '0) && (len_i <= LEN_W'(WORD_BYTES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_off  <= '0;
      sh_len  <= LEN_W'(WORD_BYTES);
      sh_mask <= '0;
      sh_val  <= '0;
      ac_off  <= '0;
      ac_len  <= LEN_W'(WORD_BYTES);
      ac_mask <= '0;
      ac_val  <= '0;
    end else begin
      if (wr_ok) begin
        sh_off  <= off_i;
        sh_len  <= len_i;
        sh_mask <= mask_i;
        sh_val  <= value_i;
      end
      if (load_i) begin
        ac_off  <= sh_off;
        ac_len  <= sh_len;
        ac_mask <= sh_mask;
        ac_val  <= sh_val;
      end
    end
  end

  // first beat already sees the rule it latches
  assign off_o   = load_i ? sh_off  : ac_off;
  assign len_o   = load_i ? sh_len  : ac_len;
  assign mask_o  = load_i ? sh_mask : ac_mask;
  assign value_o = load_i ? sh_val  : ac_val;
endmodule

// File: rtl/hfm_capture.sv
module hfm_capture #(
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned FIELD_W    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               first_i,
  input  logic [BYTE_W-1:0]  data_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic [CNT_W-1:0]   pos_o,
  output logic [FIELD_W-1:0] field_o
);
  logic [CNT_W-1:0]   cnt_q;
  logic [FIELD_W-1:0] field_q, base;

  assign pos_o = first_i ? '0 : cnt_q;
  assign base  = first_i ? '0 : field_q;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_lane
    localparam int unsigned HI = FIELD_W - 1 - k*BYTE_W;
    logic hit;
    assign hit = valid_i && (LEN_W'(k) < len_i) &&
                 (pos_o == CNT_W'(off_i) + CNT_W'(k));
    assign field_o[HI -: BYTE_W] = hit ? data_i : base[HI -: BYTE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      field_q <= '0;
    end else if (valid_i) begin
      cnt_q   <= (pos_o == '1) ? pos_o : pos_o + 1'b1;
      field_q <= field_o;
    end
  end
endmodule

// File: rtl/hfm_verdict.sv
module hfm_verdict #(
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned LEN_W      = 3,
  parameter int unsigned CNT_W      = 9,
  parameter int unsigned WORD_BYTES = 4,
  parameter int unsigned FIELD_W    = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic               last_i,
  input  logic [CNT_W-1:0]   pos_i,
  input  logic [FIELD_W-1:0] field_i,
  input  logic [OFF_W-1:0]   off_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] value_i,
  output logic               vld_o,
  output logic               match_o,
  output logic               oob_o,
  output logic               mis_o
);
  logic [CNT_W:0] span, count;
  logic           oob, mis, eq, done;

  assign span  = (CNT_W+1)'(off_i) + (CNT_W+1)'(len_i);
  assign count = {1'b0, pos_i} + 1'b1;
  assign oob   = span > count;
  assign mis   = (off_i % OFF_W'(WORD_BYTES)) != '0;
  assign eq    = (field_i & mask_i) == value_i;
  assign done  = valid_i && last_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      match_o <= 1'b0;
      oob_o   <= 1'b0;
      mis_o   <= 1'b0;
    end else begin
      vld_o   <= done;
      match_o <= done && !oob && eq;
      oob_o   <= done && oob;
      mis_o   <= done && mis;
    end
  end
endmodule

// File: rtl/hdr_field_match.sv
module hdr_field_match
  import hfm_pkg::*;
#(
  parameter int unsigned WORD_BYTES = HFM_WORD_BYTES,
  parameter int unsigned OFF_W      = HFM_OFF_W,
  localparam int unsigned LEN_W     = $clog2(WORD_BYTES + 1),
  localparam int unsigned FIELD_W   = WORD_BYTES * HFM_BYTE_W,
  localparam int unsigned CNT_W     = OFF_W + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [OFF_W-1:0]      cfg_offset_i,
  input  logic [LEN_W-1:0]      cfg_len_i,
  input  logic [FIELD_W-1:0]    cfg_mask_i,
  input  logic [FIELD_W-1:0]    cfg_value_i,
  input  logic                  s_valid_i,
  input  logic                  s_first_i,
  input  logic                  s_last_i,
  input  logic [HFM_BYTE_W-1:0] s_data_i,
  output logic                  verdict_valid_o,
  output logic                  match_o,
  output logic                  out_of_bounds_o,
  output logic                  misaligned_o
);
  logic [OFF_W-1:0]   r_off;
  logic [LEN_W-1:0]   r_len;
  logic [FIELD_W-1:0] r_mask, r_val, field;
  logic [CNT_W-1:0]   pos;
  logic               start;

  assign start = s_valid_i && s_first_i;

  hfm_cfg #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .FIELD_W(FIELD_W), .WORD_BYTES(WORD_BYTES)
  ) i_cfg (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .off_i(cfg_offset_i), .len_i(cfg_len_i),
    .mask_i(cfg_mask_i), .value_i(cfg_value_i), .load_i(start),
    .off_o(r_off), .len_o(r_len), .mask_o(r_mask), .value_o(r_val)
  );

  hfm_capture #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .BYTE_W(HFM_BYTE_W),
    .WORD_BYTES(WORD_BYTES), .FIELD_W(FIELD_W)
  ) i_cap (
    .clk_i, .rst_ni,
    .valid_i(s_valid_i), .first_i(s_first_i), .data_i(s_data_i),
    .off_i(r_off), .len_i(r_len), .pos_o(pos), .field_o(field)
  );

  hfm_verdict #(
    .OFF_W(OFF_W), .LEN_W(LEN_W), .CNT_W(CNT_W),
    .WORD_BYTES(WORD_BYTES), .FIELD_W(FIELD_W)
  ) i_vrd (
    .clk_i, .rst_ni,
    .valid_i(s_valid_i), .last_i(s_last_i), .pos_i(pos), .field_i(field),
    .off_i(r_off), .len_i(r_len), .mask_i(r_mask), .value_i(r_val),
    .vld_o(verdict_valid_o), .match_o(match_o),
    .oob_o(out_of_bounds_o), .mis_o(misaligned_o)
  );
endmodule

// File: rtl/hfm_chk.sv
module hfm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic s_valid_i,
  input logic s_last_i,
  input logic verdict_valid_o,
  input logic match_o,
  input logic out_of_bounds_o,
  input logic misaligned_o
);
  // R3
  verdict_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && s_last_i) |=> verdict_valid_o);

  // R3
  verdict_only_after_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(s_valid_i && s_last_i) |=> !verdict_valid_o);

  // R3
  idle_flags_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !verdict_valid_o |-> (!match_o && !out_of_bounds_o && !misaligned_o));

  // R4
  oob_blocks_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_of_bounds_o |-> !match_o);
endmodule

bind hdr_field_match hfm_chk i_hfm_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .s_valid_i(s_valid_i), .s_last_i(s_last_i),
  .verdict_valid_o(verdict_valid_o), .match_o(match_o),
  .out_of_bounds_o(out_of_bounds_o), .misaligned_o(misaligned_o)
);

// File: tb/test_hdr_field_match.sv
module test_hdr_field_match;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_off = '0;
  logic [2:0]  cfg_len = '0;
  logic [31:0] cfg_mask = '0, cfg_val = '0;
  logic        s_valid = 1'b0, s_first = 1'b0, s_last = 1'b0;
  logic [7:0]  s_data = '0;
  logic        v_vld, v_match, v_oob, v_mis;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  hdr_field_match i_hdr_field_match (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_offset_i(cfg_off), .cfg_len_i(cfg_len),
    .cfg_mask_i(cfg_mask), .cfg_value_i(cfg_val),
    .s_valid_i(s_valid), .s_first_i(s_first), .s_last_i(s_last), .s_data_i(s_data),
    .verdict_valid_o(v_vld), .match_o(v_match),
    .out_of_bounds_o(v_oob), .misaligned_o(v_mis)
  );

  typedef struct packed {
    logic [7:0]  off;
    logic [2:0]  len;
    logic [31:0] mask;
    logic [31:0] val;
    logic [7:0]  plen;
    logic        m, o, a;
  } vec_t;

  localparam int NV = 12;
  // packet byte i carries 8'h10 + i
  localparam vec_t VECS [NV] = '{
    '{8'd0,  3'd4, 32'hFFFFFFFF, 32'h10111213, 8'd8,  1'b1, 1'b0, 1'b0},
    '{8'd4,  3'd4, 32'hFFFFFFFF, 32'h14151617, 8'd8,  1'b1, 1'b0, 1'b0},
    '{8'd5,  3'd4, 32'hFFFFFFFF, 32'h00000000, 8'd8,  1'b0, 1'b1, 1'b1},
    '{8'd2,  3'd2, 32'hFFFF0000, 32'h12130000, 8'd8,  1'b1, 1'b0, 1'b1},
    '{8'd3,  3'd1, 32'hFF000000, 32'h13000000, 8'd8,  1'b1, 1'b0, 1'b1},
    '{8'd1,  3'd3, 32'h00FFFF00, 32'h00121300, 8'd8,  1'b1, 1'b0, 1'b1},
    '{8'd0,  3'd4, 32'hFFFFFFFF, 32'h10111214, 8'd8,  1'b0, 1'b0, 1'b0},
    '{8'd8,  3'd1, 32'hFF000000, 32'h00000000, 8'd8,  1'b0, 1'b1, 1'b0},
    '{8'd7,  3'd1, 32'hFF000000, 32'h17000000, 8'd8,  1'b1, 1'b0, 1'b1},
    '{8'd0,  3'd2, 32'hFFFFFFFF, 32'h10110000, 8'd8,  1'b1, 1'b0, 1'b0},
    '{8'd0,  3'd1, 32'h00000000, 32'h00000001, 8'd8,  1'b0, 1'b0, 1'b0},
    '{8'd12, 3'd4, 32'hFFFFFFFF, 32'h1C1D1E1F, 8'd16, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic verdict(input string req, input logic m, input logic o, input logic a);
    chk(req, v_vld,   1'b1, "verdict_valid");
    chk(req, v_match, m,    "match");
    chk(req, v_oob,   o,    "out_of_bounds");
    chk(req, v_mis,   a,    "misaligned");
  endtask

  task automatic cfg_write(input logic [7:0] o, input logic [2:0] l,
                           input logic [31:0] mk, input logic [31:0] v);
    cfg_off = o; cfg_len = l; cfg_mask = mk; cfg_val = v; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // returns at the negedge where the verdict is visible
  task automatic send_pkt(input int plen, input int gap, input int mid_at);
    for (int i = 0; i < plen; i++) begin
      s_valid = 1'b1; s_first = (i == 0); s_last = (i == plen - 1);
      s_data = 8'(8'h10 + i);
      cfg_we = (i == mid_at);
      @(negedge clk);
      cfg_we = 1'b0;
      if (gap > 0 && i != plen - 1) begin
        s_valid = 1'b0; s_data = 8'hEE;
        repeat (gap) @(negedge clk);
      end
    end
    s_valid = 1'b0; s_first = 1'b0; s_last = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", v_vld, 1'b0, "verdict_valid after reset");
    chk("R1", v_match, 1'b0, "match after reset");
    send_pkt(4, 0, -1);
    verdict("R1", 1'b1, 1'b0, 1'b0);
    send_pkt(2, 0, -1);
    verdict("R1", 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk("R3", v_vld, 1'b0, "verdict pulse width");

    // R2/R3/R4/R5 vector table
    for (int i = 0; i < NV; i++) begin
      cfg_write(VECS[i].off, VECS[i].len, VECS[i].mask, VECS[i].val);
      send_pkt(int'(VECS[i].plen), 0, -1);
      verdict($sformatf("R2/R3/R4/R5 vec%0d", i), VECS[i].m, VECS[i].o, VECS[i].a);
    end

    // R4 overrun forces match low even with mask 0 and value 0
    cfg_write(8'd6, 3'd4, 32'h0, 32'h0);
    send_pkt(8, 0, -1);
    verdict("R4", 1'b0, 1'b1, 1'b1);

    // R6 idle gaps between beats
    cfg_write(8'd2, 3'd2, 32'hFFFF0000, 32'h12130000);
    send_pkt(6, 2, -1);
    verdict("R6", 1'b1, 1'b0, 1'b1);

    // R7 mid-packet write: rule B = offset 1, value DEADBEEF
    cfg_write(8'd0, 3'd4, 32'hFFFFFFFF, 32'h10111213);
    cfg_off = 8'd1; cfg_len = 3'd4; cfg_mask = 32'hFFFFFFFF; cfg_val = 32'hDEADBEEF;
    send_pkt(8, 0, 3);
    verdict("R7 in-flight", 1'b1, 1'b0, 1'b0);
    send_pkt(8, 0, -1);
    verdict("R7 next packet", 1'b0, 1'b0, 1'b1);

    // R8 illegal lengths discarded
    cfg_write(8'd0, 3'd1, 32'hFF000000, 32'h10000000);
    cfg_write(8'd3, 3'd0, 32'h0, 32'h5);
    send_pkt(4, 0, -1);
    verdict("R8 len0", 1'b1, 1'b0, 1'b0);
    cfg_write(8'd3, 3'd5, 32'h0, 32'h5);
    send_pkt(4, 0, -1);
    verdict("R8 len5", 1'b1, 1'b0, 1'b0);

    // R9 single-beat packets
    send_pkt(1, 0, -1);
    verdict("R9", 1'b1, 1'b0, 1'b0);
    cfg_write(8'd1, 3'd1, 32'h0, 32'h0);
    send_pkt(1, 0, -1);
    verdict("R9", 1'b0, 1'b1, 1'b1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule